// File: doc/BRIEF.md
# PHY Event Interrupt Flag and Mask Unit

This block gathers seven single-cycle event pulses from a PHY's status logic (energy detected, auto-negotiation complete, remote fault, link loss, link-partner acknowledge, parallel detection fault and page received). Each pulse sets a sticky bit in a 16-bit flag register. A 16-bit enable register selects which of those bits may raise the block's single interrupt output. The interrupt stays high while any enabled flag is set.

A small register port sits behind a management serial interface. Through it, software writes the enable register and reads either register back. Reading the flag register returns the latched events and clears them in the same cycle. This removes the interrupt request unless a new event arrives. The enable register holds its value across reads. Flags latch whether or not they are enabled, so enabling a source later raises the interrupt at once if its flag is already set.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset, every flag and every enable bit is 0 and `irq` is 0. Reading either register back gives 16'h0000.
- R2: The event inputs map to flag bits as follows: `evEnergyOn` to bit 7, `evAnDone` to bit 6, `evRemoteFault` to bit 5, `evLinkLost` to bit 4, `evPartnerAck` to bit 3, `evParallelFault` to bit 2 and `evPageRx` to bit 1. The same positions apply in the enable register.
- R3: A flag bit is set on the clock edge where its event input is 1. It stays set after the input returns to 0, until a flag read clears it.
- R4: A read with `regSel`=0 selects the flag register. On the next cycle `rdValid` is 1 and `rdData` holds the flags as they were before the read. The flags are cleared on the edge of the read. A read of either register gives `rdValid`=1 exactly one cycle later.
- R5: An event pulse in the same cycle as a flag read is not returned by that read. It stays set and is returned by the following flag read.
- R6: A write with `regSel`=1 stores `wrData` into the enable register. Bits 0 and 15..8 of both registers always read 0, and writes to those bits are ignored.
- R7: `irq` is a registered output equal to the OR of (flag AND enable) over all bits. It changes on the same edge that updates the flags or the enables. It therefore goes high on the edge that latches an enabled event, and goes low on the edge of the clearing read.
- R8: Flags latch while their enable bit is 0. A later write that enables a bit whose flag is already set raises `irq` on that write's edge.
- R9: Writes with `regSel`=0 do not change the flags.
- R10: A read of the enable register (`regSel`=1) changes neither the flags nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evEnergyOn | input | 1 | Energy detected pulse |
| evAnDone | input | 1 | Auto-negotiation complete pulse |
| evRemoteFault | input | 1 | Remote fault pulse |
| evLinkLost | input | 1 | Link status lost pulse |
| evPartnerAck | input | 1 | Link-partner acknowledge pulse |
| evParallelFault | input | 1 | Parallel detection fault pulse |
| evPageRx | input | 1 | Page received pulse |
| regRead | input | 1 | Register read strobe |
| regWrite | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid when rdValid is 1 |
| rdValid | output | 1 | Read data valid, one cycle after regRead |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The assertions assume each register access is a one-cycle strobe with `regSel` stable in that cycle. They also assume event inputs are 0 while reset is asserted. The clearing and holding properties further assume a read and a write are not issued together. The bench drives every input on the falling edge and issues at most one access per cycle. It pulses events only after reset is released, so the stimulus stays inside these assumptions. Simultaneous event and read cycles are the only overlaps it creates on purpose.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W  = 16;
  localparam int SRC_LO = 1;
  localparam int SRC_HI = 7;
  localparam int SRC_N  = SRC_HI - SRC_LO + 1;
  localparam logic SEL_FLAGS = 1'b0;
  localparam logic SEL_MASK  = 1'b1;

  typedef struct packed {
    logic flagRead;
    logic maskRead;
    logic maskWrite;
  } regStrobes_t;
endpackage

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regRead,
  input  logic        regWrite,
  input  logic        regSel,
  output regStrobes_t strobes,
  output logic        rdValid
);
  always_comb begin
    strobes.flagRead  = regRead  && (regSel == SEL_FLAGS);
    strobes.maskRead  = regRead  && (regSel == SEL_MASK);
    strobes.maskWrite = regWrite && (regSel == SEL_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= regRead;
  end
endmodule

// File: rtl/phy_irq_datapath.sv
module phy_irq_datapath
  import phy_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_HI:SRC_LO] events,
  input  regStrobes_t       strobes,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              irq
);
  localparam logic [REG_W-1:0] IMPL_BITS =
    REG_W'(((1 << (SRC_HI + 1)) - 1) & ~((1 << SRC_LO) - 1));

  logic [REG_W-1:0] evFull;
  logic [REG_W-1:0] flagsQ, flagsNext;
  logic [REG_W-1:0] maskQ, maskNext;

  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : gMap
      if (b >= SRC_LO && b <= SRC_HI) begin : gSrc
        assign evFull[b] = events[b];
      end else begin : gRsv
        assign evFull[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    flagsNext = (strobes.flagRead ? '0 : flagsQ) | evFull;
    maskNext  = strobes.maskWrite ? (wrData & IMPL_BITS) : maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      maskQ  <= '0;
      irq    <= 1'b0;
      rdData <= '0;
    end else begin
      flagsQ <= flagsNext;
      maskQ  <= maskNext;
      irq    <= |(flagsNext & maskNext);
      if (strobes.flagRead)      rdData <= flagsQ;
      else if (strobes.maskRead) rdData <= maskQ;
    end
  end
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evEnergyOn,
  input  logic        evAnDone,
  input  logic        evRemoteFault,
  input  logic        evLinkLost,
  input  logic        evPartnerAck,
  input  logic        evParallelFault,
  input  logic        evPageRx,
  input  logic        regRead,
  input  logic        regWrite,
  input  logic        regSel,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        irq
);
  regStrobes_t strobes;
  logic [SRC_HI:SRC_LO] events;

  // R2: fixed bit map, energy at the top, page received at the bottom
  assign events = {evEnergyOn, evAnDone, evRemoteFault, evLinkLost,
                   evPartnerAck, evParallelFault, evPageRx};

  phy_irq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regRead(regRead), .regWrite(regWrite),
    .regSel(regSel), .strobes(strobes), .rdValid(rdValid)
  );

  phy_irq_datapath uData (
    .clk(clk), .rstN(rstN), .events(events), .strobes(strobes),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/phy_irq_check.sv
module phy_irq_check (
  input logic        clk,
  input logic        rstN,
  input logic [6:0]  evAll,
  input logic        regRead,
  input logic        regWrite,
  input logic        regSel,
  input logic [15:0] rdData,
  input logic        rdValid,
  input logic        irq
);
  // R4: read data valid exactly one cycle after a read
  a_r4_rdvalid_timing: assert property (@(posedge clk) disable iff (!rstN)
    regRead |=> rdValid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !regRead |=> !rdValid);

  // R6: reserved bits always read zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[15:8] == 8'h00 && rdData[0] == 1'b0));

  // R4/R7: a flag read with no concurrent event or write drops irq
  a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regSel == 1'b0 && !regWrite && evAll == 7'd0) |=> !irq);

  // R3: irq holds while nothing clears flags or rewrites enables
  a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regRead && regSel == 1'b0) && !regWrite) |=> irq);

  // R10: an enable-register read leaves irq unchanged
  a_r10_mask_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regSel == 1'b1 && !regWrite && evAll == 7'd0) |=> $stable(irq));
endmodule

bind phy_irq_unit phy_irq_check uChk (
  .clk(clk), .rstN(rstN),
  .evAll({evEnergyOn, evAnDone, evRemoteFault, evLinkLost,
          evPartnerAck, evParallelFault, evPageRx}),
  .regRead(regRead), .regWrite(regWrite), .regSel(regSel),
  .rdData(rdData), .rdValid(rdValid), .irq(irq)
);

// File: tb/phy_irq_unit_test.sv
module phy_irq_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:1] ev = '0;
  logic regRead = 1'b0, regWrite = 1'b0, regSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic rdValid, irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  string tagQ[$];
  logic [15:0] flagsM = '0, maskM = '0;

  always #10 clk = ~clk;

  phy_irq_unit uut (
    .clk(clk), .rstN(rstN),
    .evEnergyOn(ev[7]), .evAnDone(ev[6]), .evRemoteFault(ev[5]),
    .evLinkLost(ev[4]), .evPartnerAck(ev[3]), .evParallelFault(ev[2]),
    .evPageRx(ev[1]),
    .regRead(regRead), .regWrite(regWrite), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check("R4 unexpected rdValid", 16'h1, 16'h0);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  // driver: one cycle of stimulus, model update, irq check after the edge
  task automatic doCycle(input logic [7:1] e, input bit rd, input bit wr,
                         input bit sel, input logic [15:0] d, input string tag);
    @(negedge clk);
    ev = e; regRead = rd; regWrite = wr; regSel = sel; wrData = d;
    if (rd) begin
      expQ.push_back(sel ? maskM : flagsM);
      tagQ.push_back(tag);
    end
    flagsM = ((rd && !sel) ? 16'h0 : flagsM) | {8'h0, e, 1'b0};
    if (wr && sel) maskM = d & 16'h00FE;
    @(posedge clk); #2;
    check({tag, " irq"}, {15'h0, irq}, {15'h0, |(flagsM & maskM)});
    ev = '0; regRead = 0; regWrite = 0;
  endtask

  task automatic idle(input string tag);
    doCycle('0, 0, 0, 0, 16'h0, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    #1 check("R1 reset irq", {15'h0, irq}, 16'h0);
    doCycle('0, 1, 0, 0, 16'h0, "R1 flags after reset");
    doCycle('0, 1, 0, 1, 16'h0, "R1 mask after reset");
    // R2/R3/R4/R8: each source alone, masked off
    for (int b = 1; b <= 7; b++) begin
      doCycle(7'(1 << (b - 1)), 0, 0, 0, 16'h0, "R2 pulse");
      idle("R3 hold");
      doCycle('0, 1, 0, 0, 16'h0, "R2 bit position");
      doCycle('0, 1, 0, 0, 16'h0, "R4 cleared");
    end
    // R6: reserved bits
    doCycle('0, 0, 1, 1, 16'hFFFF, "R6 write all");
    doCycle('0, 1, 0, 1, 16'h0, "R6 mask readback");
    doCycle('0, 0, 1, 1, 16'h0000, "R6 clear mask");
    // R9: flag register not writable
    doCycle('0, 0, 1, 0, 16'hFFFF, "R9 write flags");
    doCycle('0, 1, 0, 0, 16'h0, "R9 flags unchanged");
    // R7/R10/R3
    doCycle('0, 0, 1, 1, 16'h0020, "R7 enable bit5");
    doCycle(7'b0100000, 0, 0, 0, 16'h0, "R7 masked source");
    doCycle(7'b0010000, 0, 0, 0, 16'h0, "R7 enabled source");
    idle("R3 irq held");
    doCycle('0, 1, 0, 1, 16'h0, "R10 mask read");
    idle("R10 irq unchanged");
    doCycle('0, 1, 0, 0, 16'h0, "R4 read clears 0060");
    idle("R7 irq low after clear");
    // R8: flag latched while disabled, then enabled
    doCycle('0, 0, 1, 1, 16'h0000, "R8 disable all");
    doCycle(7'b0000010, 0, 0, 0, 16'h0, "R8 latch disabled");
    doCycle('0, 0, 1, 1, 16'h0004, "R8 enable later");
    // R5: event during clearing read
    doCycle(7'b1000000, 1, 0, 0, 16'h0, "R5 read with event");
    doCycle('0, 1, 0, 0, 16'h0, "R5 event kept");
    doCycle(7'b1111111, 0, 0, 0, 16'h0, "R2 all sources");
    doCycle('0, 0, 1, 1, 16'h00FE, "R7 enable all");
    doCycle('0, 1, 0, 0, 16'h0, "R2 all flags");
    idle("R7 final");
    idle("R7 final");
    check("R4 queue drained", 16'(expQ.size()), 16'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule